// File: doc/BRIEF.md
# Programmable-Flag Dual-Clock FIFO

This block is a first-in first-out buffer that connects a producer running on a write clock to a consumer running on an unrelated read clock. Each side has two active-LOW enables, and a word moves only when both enables of that side are LOW. Four flags report the fill state: empty and almost-empty belong to the read clock, and full and almost-full belong to the write clock. Every flag is active-LOW. The read and write pointers cross between the clocks as Gray codes through two-flop synchronizers. A flag may therefore release a few cycles late, but it never asserts late.

The almost-empty threshold n and the almost-full threshold m are held in a bank of four offset registers that share the data bus. When the load input `prog_n` is LOW, a write goes into the offset register picked by a write-side sequencer, and a read puts the offset register picked by a read-side sequencer onto `dout`. Each sequencer is a four-state machine: EMPTY_LO → EMPTY_HI → FULL_LO → FULL_HI → back to EMPTY_LO. A state advances only on an offset access, so a partial load resumes where it stopped. A low register holds bits [8:0] of its threshold. A high register holds the bits above bit 8 and reads back with its unused bits as zero.

Top module: `pflag_fifo`

## Requirements
- R1: After reset, `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1 and `dout`=0. Both thresholds are 7, and both sequencers are in EMPTY_LO. A readback of the four registers therefore returns 7, 0, 7, 0.
- R2: With `prog_n`=1, `wen_a_n`=0 and `wen_b_n`=0, and the FIFO not full, a rising `wclk` stores `din`. Words leave in the order they were stored.
- R3: If either write enable is 1, a rising `wclk` changes neither the FIFO nor any offset register nor the write sequencer, whatever the level of `prog_n`.
- R4: With `prog_n`=0 and both write enables 0, each rising `wclk` writes `din` into the register named by the write sequencer and then advances it. The transitions are EMPTY_LO→EMPTY_HI, EMPTY_HI→FULL_LO, FULL_LO→FULL_HI and FULL_HI→EMPTY_LO.
- R5: Raising `prog_n` holds the write sequencer in its state. The next offset write after `prog_n` falls again lands in the following register, not in EMPTY_LO.
- R6: With `prog_n`=0 and both read enables 0, each rising `rclk` puts the register named by the read sequencer onto `dout` and advances the read sequencer in the same order as R4. High registers read back zero above their stored bits, and a readback takes no word from the FIFO.
- R7: `empty_n` is 0 exactly when the FIFO holds no word. While it is 0, reads are ignored and `dout` holds its value.
- R8: `full_n` is 0 exactly when the FIFO holds DEPTH words. While it is 0, writes are ignored.
- R9: Once the read side has settled, `aempty_n` is 0 when the word count is at most n and 1 when it is n+1 or more. n is formed as {EMPTY_HI, EMPTY_LO}.
- R10: Once the write side has settled, `afull_n` is 0 when the word count is at least DEPTH−m and 1 when more than m locations are free. m is formed as {FULL_HI, FULL_LO}.
- R11: Gray pointers change by one bit per step. After a write, `empty_n` is 1 no later than the third rising `rclk` edge that follows it.
- R12: With `prog_n`=1, both read enables 0 and the FIFO not empty, a rising `rclk` loads the oldest word onto `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active LOW, shared by both domains |
| wen_a_n | input | 1 | Write enable A, active LOW |
| wen_b_n | input | 1 | Write enable B, active LOW |
| prog_n | input | 1 | LOW selects the offset registers instead of the FIFO array |
| din | input | DW | Write data or offset value |
| ren_a_n | input | 1 | Read enable A, active LOW |
| ren_b_n | input | 1 | Read enable B, active LOW |
| dout | output | DW | Read data or offset readback, registered on `rclk` |
| full_n | output | 1 | Full flag, active LOW, `wclk` domain |
| afull_n | output | 1 | Almost-full flag, active LOW, `wclk` domain |
| empty_n | output | 1 | Empty flag, active LOW, `rclk` domain |
| aempty_n | output | 1 | Almost-empty flag, active LOW, `rclk` domain |

## Verification
If the write sequencer is in the wrong state, the next four-word readback returns a shifted or stale word. It is seen as soon as the read sequencer reaches the register that was hit. If a pointer or its synchronized copy is wrong, the flags settle at the wrong fill level, which is visible a few cycles after the traffic stops. It also shows on `dout` as a swapped, repeated or lost word on the very next FIFO read, because every accepted read is compared against a queue model.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

    // Offset-register sequencer states; the order is the load and readback order.
    typedef enum logic [1:0] {
        SEL_EMPTY_LO = 2'd0,
        SEL_EMPTY_HI = 2'd1,
        SEL_FULL_LO  = 2'd2,
        SEL_FULL_HI  = 2'd3
    } ofs_sel_e;

    function automatic ofs_sel_e sel_after(input ofs_sel_e s);
        case (s)
            SEL_EMPTY_LO: return SEL_EMPTY_HI;
            SEL_EMPTY_HI: return SEL_FULL_LO;
            SEL_FULL_LO:  return SEL_FULL_HI;
            default:      return SEL_EMPTY_LO;
        endcase
    endfunction

endpackage

// File: rtl/pflag_ptr.sv
// Binary pointer with a registered Gray copy for crossing to the other clock.
module pflag_ptr #(
    parameter int PW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [PW-1:0] bin,
    output logic [PW-1:0] gray
);

    logic [PW-1:0] bin_q;
    logic [PW-1:0] bin_d;
    logic [PW-1:0] gray_q;

    assign bin_d = bin_q + PW'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_d;
            gray_q <= bin_d ^ (bin_d >> 1);
        end
    end

    assign bin  = bin_q;
    assign gray = gray_q;

endmodule

// File: rtl/pflag_sync.sv
// Multi-flop synchronizer for a Gray pointer, followed by Gray-to-binary decode.
module pflag_sync #(
    parameter int PW     = 11,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);

    logic [PW-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= gray_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = PW - 1; i >= 0; i--) begin
            acc        = acc ^ stg_q[STAGES-1][i];
            bin_out[i] = acc;
        end
    end

endmodule

// File: rtl/pflag_ofs_bank.sv
// Four offset registers loaded in a fixed order by a write-clock sequencer.
module pflag_ofs_bank
    import pflag_pkg::*;
#(
    parameter int DW  = 9,
    parameter int OW  = 10,
    parameter int DEF = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_strobe,
    input  logic [DW-1:0]   din,
    output logic [OW-1:0]   n_thr,
    output logic [OW-1:0]   m_thr,
    output logic [4*DW-1:0] rb_bus
);

    localparam int            HW    = OW - DW;
    localparam logic [OW-1:0] DEF_V = OW'(DEF);

    ofs_sel_e      sel_q;
    ofs_sel_e      sel_d;
    logic [DW-1:0] e_lo_q;
    logic [DW-1:0] f_lo_q;
    logic [HW-1:0] e_hi_q;
    logic [HW-1:0] f_hi_q;

    // Next-state: advance only on an offset write.
    always_comb begin
        sel_d = sel_q;
        if (ld_strobe) sel_d = sel_after(sel_q);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= SEL_EMPTY_LO;
        else        sel_q <= sel_d;
    end

    // Register bank written in the current state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_lo_q <= DEF_V[DW-1:0];
            e_hi_q <= DEF_V[OW-1:DW];
            f_lo_q <= DEF_V[DW-1:0];
            f_hi_q <= DEF_V[OW-1:DW];
        end else if (ld_strobe) begin
            unique case (sel_q)
                SEL_EMPTY_LO: e_lo_q <= din;
                SEL_EMPTY_HI: e_hi_q <= din[HW-1:0];
                SEL_FULL_LO:  f_lo_q <= din;
                SEL_FULL_HI:  f_hi_q <= din[HW-1:0];
            endcase
        end
    end

    assign n_thr  = {e_hi_q, e_lo_q};
    assign m_thr  = {f_hi_q, f_lo_q};
    assign rb_bus = {DW'(f_hi_q), f_lo_q, DW'(e_hi_q), e_lo_q};

endmodule

// File: rtl/pflag_fifo.sv
// Dual-clock FIFO with programmable almost-empty / almost-full thresholds.
module pflag_fifo
    import pflag_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int DW      = 9,
    parameter int DEF_OFS = 7
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wen_a_n,
    input  logic          wen_b_n,
    input  logic          prog_n,
    input  logic [DW-1:0] din,
    input  logic          ren_a_n,
    input  logic          ren_b_n,
    output logic [DW-1:0] dout,
    output logic          full_n,
    output logic          afull_n,
    output logic          empty_n,
    output logic          aempty_n
);

    localparam int            AW      = $clog2(DEPTH);
    localparam int            PW      = AW + 1;
    localparam int            OW      = AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    // ---------------- write clock domain ----------------
    logic          wr_req;
    logic          fifo_wr;
    logic          ofs_wr;
    logic [PW-1:0] wptr_bin;
    logic [PW-1:0] wptr_gray;
    logic [PW-1:0] rptr_wsync;
    logic [PW-1:0] wcount;
    logic [OW-1:0] n_thr;
    logic [OW-1:0] m_thr;
    logic [4*DW-1:0] rb_bus;
    logic [DW-1:0] mem [DEPTH];

    assign wr_req  = !wen_a_n && !wen_b_n;
    assign fifo_wr = wr_req && prog_n && full_n;
    assign ofs_wr  = wr_req && !prog_n;

    pflag_ptr #(.PW(PW)) u_wptr (
        .clk   (wclk),
        .rst_n (rst_n),
        .inc   (fifo_wr),
        .bin   (wptr_bin),
        .gray  (wptr_gray)
    );

    pflag_ofs_bank #(.DW(DW), .OW(OW), .DEF(DEF_OFS)) u_bank (
        .clk       (wclk),
        .rst_n     (rst_n),
        .ld_strobe (ofs_wr),
        .din       (din),
        .n_thr     (n_thr),
        .m_thr     (m_thr),
        .rb_bus    (rb_bus)
    );

    always_ff @(posedge wclk) begin
        if (fifo_wr) mem[wptr_bin[AW-1:0]] <= din;
    end

    // ---------------- read clock domain ----------------
    logic          rd_req;
    logic          fifo_rd;
    logic          ofs_rd;
    logic [PW-1:0] rptr_bin;
    logic [PW-1:0] rptr_gray;
    logic [PW-1:0] wptr_rsync;
    logic [PW-1:0] rcount;
    ofs_sel_e      rsel_q;
    ofs_sel_e      rsel_d;

    assign rd_req  = !ren_a_n && !ren_b_n;
    assign fifo_rd = rd_req && prog_n && empty_n;
    assign ofs_rd  = rd_req && !prog_n;

    pflag_ptr #(.PW(PW)) u_rptr (
        .clk   (rclk),
        .rst_n (rst_n),
        .inc   (fifo_rd),
        .bin   (rptr_bin),
        .gray  (rptr_gray)
    );

    pflag_sync #(.PW(PW), .STAGES(2)) u_rsync (
        .clk     (wclk),
        .rst_n   (rst_n),
        .gray_in (rptr_gray),
        .bin_out (rptr_wsync)
    );

    pflag_sync #(.PW(PW), .STAGES(2)) u_wsync (
        .clk     (rclk),
        .rst_n   (rst_n),
        .gray_in (wptr_gray),
        .bin_out (wptr_rsync)
    );

    // Readback sequencer: next state.
    always_comb begin
        rsel_d = rsel_q;
        if (ofs_rd) rsel_d = sel_after(rsel_q);
    end

    // Readback sequencer: state register.
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) rsel_q <= SEL_EMPTY_LO;
        else        rsel_q <= rsel_d;
    end

    // Output register: FIFO word or selected offset register.
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (fifo_rd) begin
            dout <= mem[rptr_bin[AW-1:0]];
        end else if (ofs_rd) begin
            unique case (rsel_q)
                SEL_EMPTY_LO: dout <= rb_bus[0*DW +: DW];
                SEL_EMPTY_HI: dout <= rb_bus[1*DW +: DW];
                SEL_FULL_LO:  dout <= rb_bus[2*DW +: DW];
                SEL_FULL_HI:  dout <= rb_bus[3*DW +: DW];
            endcase
        end
    end

    // ---------------- flags ----------------
    assign wcount   = wptr_bin - rptr_wsync;
    assign full_n   = (wcount != DEPTH_P);
    assign afull_n  = ((DEPTH_P - wcount) > {1'b0, m_thr});

    assign rcount   = wptr_rsync - rptr_bin;
    assign empty_n  = (rcount != '0);
    assign aempty_n = (rcount > {1'b0, n_thr});

endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
    parameter int PW = 11
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          prog_n,
    input logic          wen_a_n,
    input logic          wen_b_n,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic [PW-1:0] wptr_bin,
    input logic [PW-1:0] wptr_gray,
    input logic [PW-1:0] rptr_bin
);

    p_full_blocks_write_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> (wptr_bin == $past(wptr_bin)));

    p_empty_blocks_read_r7: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> (rptr_bin == $past(rptr_bin)));

    p_full_implies_afull_r10: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    p_empty_implies_aempty_r9: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    p_gray_one_bit_r11: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

    p_idle_no_write_r3: assert property (@(posedge wclk) disable iff (!rst_n)
        (wen_a_n || wen_b_n) |=> $stable(wptr_bin));

    p_load_no_fifo_write_r4: assert property (@(posedge wclk) disable iff (!rst_n)
        !prog_n |=> $stable(wptr_bin));

    p_readback_no_pop_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        !prog_n |=> $stable(rptr_bin));

    p_wptr_step_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        (wptr_bin == $past(wptr_bin)) || (wptr_bin == $past(wptr_bin) + 1'b1));

endmodule

bind pflag_fifo pflag_fifo_chk #(.PW(PW)) u_chk (
    .wclk      (wclk),
    .rclk      (rclk),
    .rst_n     (rst_n),
    .prog_n    (prog_n),
    .wen_a_n   (wen_a_n),
    .wen_b_n   (wen_b_n),
    .full_n    (full_n),
    .afull_n   (afull_n),
    .empty_n   (empty_n),
    .aempty_n  (aempty_n),
    .wptr_bin  (wptr_bin),
    .wptr_gray (wptr_gray),
    .rptr_bin  (rptr_bin)
);

// File: tb/pflag_fifo_test.sv
module pflag_fifo_test;

    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int DEPTH       = 1024;
    localparam int DW          = 9;
    localparam int HW          = $clog2(DEPTH) - DW;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wen_a_n = 1'b1, wen_b_n = 1'b1, prog_n = 1'b1;
    logic          ren_a_n = 1'b1, ren_b_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          full_n, afull_n, empty_n, aempty_n;

    always #(CLK_PERIOD/2)  wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    pflag_fifo #(.DEPTH(DEPTH), .DW(DW), .DEF_OFS(7)) uut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wen_a_n(wen_a_n), .wen_b_n(wen_b_n), .prog_n(prog_n), .din(din),
        .ren_a_n(ren_a_n), .ren_b_n(ren_b_n), .dout(dout),
        .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model
    logic [DW-1:0] q [$];
    logic [DW-1:0] ofs_m [4] = '{9'd7, 9'd0, 9'd7, 9'd0};
    int            wsel_m = 0;
    int            rsel_m = 0;
    logic [DW-1:0] dout_m = '0;

    function automatic int thr_n();
        return (int'(ofs_m[1]) << DW) | int'(ofs_m[0]);
    endfunction

    function automatic int thr_m();
        return (int'(ofs_m[3]) << DW) | int'(ofs_m[2]);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_flags(string req);
        int cnt;
        cnt = q.size();
        check({req, " empty_n"},  int'(empty_n),  int'(cnt != 0));
        check({req, " aempty_n"}, int'(aempty_n), int'(cnt > thr_n()));
        check({req, " full_n"},   int'(full_n),   int'(cnt != DEPTH));
        check({req, " afull_n"},  int'(afull_n),  int'((DEPTH - cnt) > thr_m()));
    endtask

    task automatic wr(bit prg, bit a, bit b, logic [DW-1:0] d);
        @(negedge wclk);
        prog_n = prg; wen_a_n = a; wen_b_n = b; din = d;
        @(posedge wclk);
        #1;
        wen_a_n = 1'b1; wen_b_n = 1'b1;
        if (!a && !b) begin
            if (prg) begin
                if (q.size() < DEPTH) q.push_back(d);
            end else begin
                ofs_m[wsel_m] = (wsel_m % 2 == 1) ? (d & DW'((1 << HW) - 1)) : d;
                wsel_m = (wsel_m + 1) % 4;
            end
        end
    endtask

    task automatic rd(string req, bit prg, bit a, bit b);
        @(negedge rclk);
        prog_n = prg; ren_a_n = a; ren_b_n = b;
        @(posedge rclk);
        #1;
        ren_a_n = 1'b1; ren_b_n = 1'b1;
        if (!a && !b) begin
            if (prg) begin
                if (q.size() > 0) dout_m = q.pop_front();
            end else begin
                dout_m = ofs_m[rsel_m];
                rsel_m = (rsel_m + 1) % 4;
            end
        end
        check({req, " dout"}, int'(dout), int'(dout_m));
    endtask

    task automatic idle();
        @(negedge wclk);
        prog_n = 1'b1; wen_a_n = 1'b1; wen_b_n = 1'b1; ren_a_n = 1'b1; ren_b_n = 1'b1;
        repeat (4) @(posedge rclk);
        repeat (4) @(posedge wclk);
        #1;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd5117));
        repeat (3) @(posedge wclk);
        rst_n = 1'b1;
        #1;

        // R1: reset state and default thresholds
        check_flags("R1 reset");
        check("R1 reset dout", int'(dout), 0);
        for (int i = 0; i < 4; i++) rd("R1 R6 default readback", 1'b0, 1'b0, 1'b0);
        idle();

        // R4: load all four registers, high part keeps only its low bit
        wr(1'b0, 1'b0, 1'b0, 9'd3);
        wr(1'b0, 1'b0, 1'b0, 9'd0);
        wr(1'b0, 1'b0, 1'b0, 9'd6);
        wr(1'b0, 1'b0, 1'b0, 9'h1FE);
        idle();
        for (int i = 0; i < 4; i++) rd("R4 R6 full load readback", 1'b0, 1'b0, 1'b0);
        idle();

        // R5: partial load resumes at the next register
        wr(1'b0, 1'b0, 1'b0, 9'd20);
        idle();
        wr(1'b0, 1'b0, 1'b0, 9'h001);
        idle();
        for (int i = 0; i < 4; i++) rd("R5 partial load readback", 1'b0, 1'b0, 1'b0);
        idle();
        check("R5 n threshold", thr_n(), 532);
        wr(1'b0, 1'b0, 1'b0, 9'd9);
        wr(1'b0, 1'b0, 1'b0, 9'd0);
        wr(1'b0, 1'b0, 1'b0, 9'd3);
        wr(1'b0, 1'b0, 1'b0, 9'd0);
        wr(1'b0, 1'b0, 1'b0, 9'd9);
        idle();

        // R3: single enable does nothing in either mode
        wr(1'b0, 1'b1, 1'b0, 9'd55);
        wr(1'b0, 1'b0, 1'b1, 9'd66);
        wr(1'b1, 1'b1, 1'b0, 9'd77);
        wr(1'b1, 1'b0, 1'b1, 9'd88);
        idle();
        check_flags("R3 no fifo write");
        wr(1'b0, 1'b0, 1'b0, 9'd0);
        idle();
        for (int i = 0; i < 4; i++) rd("R3 offsets unchanged", 1'b0, 1'b0, 1'b0);
        idle();
        check("R3 R10 m threshold", thr_m(), 9);

        // R11: empty flag release latency
        wr(1'b1, 1'b0, 1'b0, 9'h0A5);
        repeat (3) @(posedge rclk);
        #1;
        check("R11 empty_n after three rclk edges", int'(empty_n), 1);
        idle();
        check_flags("R11 one word");

        // R9: almost-empty boundary at n = 3
        wr(1'b1, 1'b0, 1'b0, 9'h011);
        wr(1'b1, 1'b0, 1'b0, 9'h022);
        idle();
        check("R9 count equals n", int'(aempty_n), 0);
        wr(1'b1, 1'b0, 1'b0, 9'h033);
        idle();
        check("R9 count n plus one", int'(aempty_n), 1);
        check_flags("R9 settled");

        // R6: readback does not pop
        rd("R6 readback with data", 1'b0, 1'b0, 1'b0);
        idle();
        check_flags("R6 no pop");
        rd("R12 head after readback", 1'b1, 1'b0, 1'b0);
        idle();
        check_flags("R12 after pop");

        // Random traffic in settled write and read phases
        for (int it = 0; it < 25; it++) begin
            int len;
            len = $urandom_range(0, 40);
            for (int k = 0; k < len; k++)
                wr(1'b1, ($urandom % 4) == 0, ($urandom % 4) == 0, DW'($urandom));
            idle();
            check_flags("R2 R9 random fill");
            len = $urandom_range(0, 40);
            for (int k = 0; k < len; k++)
                rd("R12 R2 random read", 1'b1, ($urandom % 4) == 0, ($urandom % 4) == 0);
            idle();
            check_flags("R7 R9 random drain");
        end

        // R10 / R8: fill to the almost-full edge, then to full, then overfill
        while (q.size() < DEPTH - thr_m() - 1) wr(1'b1, 1'b0, 1'b0, DW'($urandom));
        idle();
        check("R10 one short of threshold", int'(afull_n), 1);
        wr(1'b1, 1'b0, 1'b0, DW'($urandom));
        idle();
        check("R10 at DEPTH-m", int'(afull_n), 0);
        while (q.size() < DEPTH) wr(1'b1, 1'b0, 1'b0, DW'($urandom));
        idle();
        check("R8 full flag", int'(full_n), 0);
        for (int k = 0; k < 3; k++) wr(1'b1, 1'b0, 1'b0, 9'h1FF);
        idle();
        check_flags("R8 overfill ignored");

        // Drain everything; extra writes must not appear
        while (q.size() > 0) rd("R8 R2 drain order", 1'b1, 1'b0, 1'b0);
        idle();
        check_flags("R7 drained");
        rd("R7 read on empty holds dout", 1'b1, 1'b0, 1'b0);
        rd("R7 read on empty holds dout", 1'b1, 1'b0, 1'b0);
        idle();
        check_flags("R7 still empty");

        done = 1'b1;
        finish_run();
    end

endmodule